// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits between the register port of an SPI controller and its serial shifter. It owns a transmit FIFO and a receive FIFO, each storing bytes, and presents their fill levels, threshold conditions and error conditions through an event register. A mask register selects which event bits drive a single interrupt line. Software loads the transmit FIFO with 32-bit or single-byte writes. It drains the receive FIFO with 32-bit reads, which take four bytes, or with byte reads, which take one. The shifter moves one byte per cycle through simple push and pop strobes.

The event word packs both byte counts next to the flag bits, so one read gives the whole FIFO picture. The receive not-empty and transmit not-full conditions compare the counts against thresholds held in the mode register. The flag bits latch, and software clears them by writing ones.

Top module: `spi_fifo_event_unit`

## Requirements
- R1: After reset, the register map reads as follows. Address 0 (mode) reads 0x00000403: the transmit threshold of 4 is in bits 13:8 and the receive threshold of 3 is in bits 5:0. Address 2 (mask) reads 0. Address 1 (event) reads 0x00000100 once two cycles have passed. The irq output is low. Address 3 is transmit data and address 4 is receive data.
- R2: Event bits 29:24 always show the number of bytes in the receive FIFO, and bits 21:16 show the number of bytes in the transmit FIFO.
- R3: A 32-bit read of address 4 returns the oldest byte in bits 31:24 and the next three bytes below it, and removes four bytes. A byte read (reg_byte=1) returns the oldest byte in bits 7:0 and removes one byte.
- R4: A 32-bit write to address 3 queues bits 31:24 first, then 23:16, 15:8 and 7:0. A byte write queues bits 7:0 only. tx_head shows the oldest byte, tx_has_data is high while the FIFO holds data, and each tx_pop removes one byte.
- R5: Event bit 9 is set in the cycle after the receive count exceeds the receive threshold. Event bit 8 is set in the cycle after the free transmit space is at least the transmit threshold.
- R6: Writing a one to an event bit clears it, unless its set condition holds in that same cycle. Writing all ones clears every flag whose condition is absent. The count fields are never changed by writes to the event register.
- R7: Mask bits use the same positions as the event flags (9, 8, 3, 2, 1, 0). irq is high exactly when some event bit is set and its mask bit is also set.
- R8: A push that would exceed capacity is dropped in full and the count stays the same. Such a push sets sticky bit 0 for the receive side and bit 2 for the transmit side.
- R9: A pop that asks for more bytes than the FIFO holds is dropped in full and the count stays the same. This includes a 32-bit read when fewer than four bytes are held. Such a pop sets sticky bit 1 for the receive side and bit 3 for the transmit side.
- R10: Each FIFO accepts exactly 32 bytes. A count of 32 is reported as 32 and means full.
- R11: A push and a pop on the same FIFO in one cycle both take effect, so a one-byte push and a one-byte pop leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on receive data) |
| reg_byte | input | 1 | 1 = byte-wide access, 0 = 32-bit access |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| rx_push | input | 1 | Shifter delivers one received byte |
| rx_push_data | input | 8 | Received byte |
| tx_pop | input | 1 | Shifter takes one byte to transmit |
| tx_head | output | 8 | Oldest byte in the transmit FIFO |
| tx_has_data | output | 1 | Transmit FIFO not empty |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a few things about the inputs. At most one register access arrives per cycle. The shifter strobes move a single byte. Reset is held for at least one edge before traffic starts. The stimulus follows these rules: it drives each register access for exactly one cycle and never raises read and write together. The only deliberate overlap is a shifter push in the same cycle as a receive-side byte read. Overfill and overdrain are done on purpose, and each one follows a fill or drain to a known count, so the dropped operation can be seen at the count fields.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    // Register indices on the register port
    typedef enum logic [2:0] {
        ADDR_MODE = 3'd0,
        ADDR_EVT  = 3'd1,
        ADDR_MASK = 3'd2,
        ADDR_TXD  = 3'd3,
        ADDR_RXD  = 3'd4
    } reg_addr_e;

    // Field placement inside the mode and event words
    localparam int RXTHR_LSB   = 0;
    localparam int TXTHR_LSB   = 8;
    localparam int RXCNT_LSB   = 24;
    localparam int TXCNT_LSB   = 16;
    localparam int CNT_FW      = 6;
    localparam int BIT_RX_NE   = 9;
    localparam int BIT_TX_NF   = 8;
    localparam int BIT_TX_UDF  = 3;
    localparam int BIT_TX_OVF  = 2;
    localparam int BIT_RX_UDF  = 1;
    localparam int BIT_RX_OVF  = 0;

    localparam int RXTHR_RESET = 3;
    localparam int TXTHR_RESET = 4;

    typedef struct packed {
        logic rx_ne;
        logic tx_nf;
        logic tx_udf;
        logic tx_ovf;
        logic rx_udf;
        logic rx_ovf;
    } flag_t;

    function automatic logic [31:0] flags_to_word(flag_t f);
        logic [31:0] w;
        w = '0;
        w[BIT_RX_NE]  = f.rx_ne;
        w[BIT_TX_NF]  = f.tx_nf;
        w[BIT_TX_UDF] = f.tx_udf;
        w[BIT_TX_OVF] = f.tx_ovf;
        w[BIT_RX_UDF] = f.rx_udf;
        w[BIT_RX_OVF] = f.rx_ovf;
        return w;
    endfunction

    function automatic flag_t word_to_flags(logic [31:0] w);
        flag_t f;
        f.rx_ne  = w[BIT_RX_NE];
        f.tx_nf  = w[BIT_TX_NF];
        f.tx_udf = w[BIT_TX_UDF];
        f.tx_ovf = w[BIT_TX_OVF];
        f.rx_udf = w[BIT_RX_UDF];
        f.rx_ovf = w[BIT_RX_OVF];
        return f;
    endfunction

endpackage

// File: rtl/sfe_byte_fifo.sv
// Byte FIFO with up to LANES bytes pushed or popped per cycle.
// A request that does not fit is dropped whole and flagged.
// DEPTH must be a power of two.
module sfe_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NW-1:0]         push_n,
    input  logic [LANES-1:0][7:0] push_data,
    input  logic [NW-1:0]         pop_n,
    output logic [CW-1:0]         count_o,
    output logic [LANES-1:0][7:0] peek_o,
    output logic                  ovf_o,
    output logic                  udf_o
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         wptr;
        logic [PW-1:0]         rptr;
        logic [CW-1:0]         count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push_fit, pop_fit, push_go, pop_go;

    always_comb begin
        st_d     = st_q;
        push_fit = ((CW+1)'(st_q.count) + (CW+1)'(push_n)) <= (CW+1)'(DEPTH);
        pop_fit  = (CW+1)'(pop_n) <= (CW+1)'(st_q.count);
        push_go  = (push_n != '0) && push_fit;
        pop_go   = (pop_n != '0) && pop_fit;
        ovf_o    = (push_n != '0) && !push_fit;
        udf_o    = (pop_n != '0) && !pop_fit;

        for (int i = 0; i < LANES; i++) begin
            if (push_go && (NW'(i) < push_n)) begin
                st_d.mem[st_q.wptr + PW'(i)] = push_data[i];
            end
        end
        if (push_go) begin
            st_d.wptr  = st_q.wptr + PW'(push_n);
        end
        if (pop_go) begin
            st_d.rptr  = st_q.rptr + PW'(pop_n);
        end
        st_d.count = st_q.count
                   + (push_go ? CW'(push_n) : '0)
                   - (pop_go  ? CW'(pop_n)  : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            peek_o[i] = st_q.mem[st_q.rptr + PW'(i)];
        end
    end

    assign count_o = st_q.count;

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    p_drop_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_n != '0) && (int'(st_q.count) + int'(push_n) > DEPTH) && (pop_n == '0))
        |=> $stable(st_q.count));

    p_drop_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pop_n != '0) && (int'(pop_n) > int'(st_q.count)) && (push_n == '0))
        |=> $stable(st_q.count));

    p_push_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_n == NW'(1)) && (pop_n == NW'(1)) && (st_q.count != '0)
         && (st_q.count != CW'(DEPTH)))
        |=> $stable(st_q.count));

endmodule

// File: rtl/sfe_event_ctrl.sv
// Mode thresholds, latched event flags with write-one-to-clear, mask and irq.
module sfe_event_ctrl
    import sfe_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_we,
    input  logic          mask_we,
    input  logic          evt_we,
    input  logic [31:0]   wdata,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_ovf,
    input  logic          rx_udf,
    input  logic          tx_ovf,
    input  logic          tx_udf,
    output logic [CW-1:0] rx_thr_o,
    output logic [CW-1:0] tx_thr_o,
    output flag_t         flags_o,
    output flag_t         mask_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [CW-1:0] rx_thr;
        logic [CW-1:0] tx_thr;
        flag_t         flags;
        flag_t         mask;
    } ec_st_t;

    ec_st_t st_d, st_q;
    flag_t  set_v, clr_v;
    logic   ne_cond, nf_cond;
    logic   unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        ne_cond = rx_count > st_q.rx_thr;
        nf_cond = ((CW+1)'(DEPTH) - (CW+1)'(tx_count)) >= (CW+1)'(st_q.tx_thr);

        set_v        = '0;
        set_v.rx_ne  = ne_cond;
        set_v.tx_nf  = nf_cond;
        set_v.rx_ovf = rx_ovf;
        set_v.rx_udf = rx_udf;
        set_v.tx_ovf = tx_ovf;
        set_v.tx_udf = tx_udf;

        clr_v = evt_we ? word_to_flags(wdata) : '0;

        st_d       = st_q;
        st_d.flags = flag_t'((st_q.flags & ~clr_v) | set_v);
        if (mode_we) begin
            st_d.rx_thr = wdata[RXTHR_LSB +: CW];
            st_d.tx_thr = wdata[TXTHR_LSB +: CW];
        end
        if (mask_we) begin
            st_d.mask = word_to_flags(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.rx_thr <= CW'(RXTHR_RESET);
            st_q.tx_thr <= CW'(TXTHR_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_thr_o = st_q.rx_thr;
    assign tx_thr_o = st_q.tx_thr;
    assign flags_o  = st_q.flags;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.flags & st_q.mask);

    p_ne_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count > st_q.rx_thr) |=> st_q.flags.rx_ne);

    p_rx_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |=> st_q.flags.rx_ovf);

    p_tx_udf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_udf |=> st_q.flags.tx_udf);

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_we && wdata[BIT_RX_UDF] && !rx_udf) |=> !st_q.flags.rx_udf);

    p_thr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(st_q.rx_thr) && $stable(st_q.tx_thr));

endmodule

// File: rtl/spi_fifo_event_unit.sv
// SPI FIFO event and interrupt unit: register decode, two byte FIFOs,
// event/mask logic and read data assembly.
module spi_fifo_event_unit
    import sfe_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_byte,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_push,
    input  logic [7:0]  rx_push_data,
    input  logic        tx_pop,
    output logic [7:0]  tx_head,
    output logic        tx_has_data,
    output logic        irq
);

    localparam int LANES = 4;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NW    = $clog2(LANES + 1);

    reg_addr_e            addr;
    logic [NW-1:0]        tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [LANES-1:0][7:0] tx_push_data, rx_lane_data;
    logic [LANES-1:0][7:0] tx_peek, rx_peek;
    logic [CW-1:0]        tx_count, rx_count, rx_thr, tx_thr;
    logic                 tx_ovf, tx_udf, rx_ovf, rx_udf;
    flag_t                flags, mask;
    logic                 unused_tx_peek;

    assign addr = reg_addr_e'(reg_addr);

    // Request sizes and lane data for both FIFOs
    always_comb begin
        tx_push_n    = '0;
        tx_push_data = '0;
        if (reg_wr && addr == ADDR_TXD) begin
            if (reg_byte) begin
                tx_push_n       = NW'(1);
                tx_push_data[0] = reg_wdata[7:0];
            end else begin
                tx_push_n = NW'(LANES);
                for (int i = 0; i < LANES; i++) begin
                    tx_push_data[i] = reg_wdata[(LANES-1-i)*8 +: 8];
                end
            end
        end
        rx_pop_n = '0;
        if (reg_rd && addr == ADDR_RXD) begin
            rx_pop_n = reg_byte ? NW'(1) : NW'(LANES);
        end
        tx_pop_n        = tx_pop  ? NW'(1) : '0;
        rx_push_n       = rx_push ? NW'(1) : '0;
        rx_lane_data    = '0;
        rx_lane_data[0] = rx_push_data;
    end

    sfe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (tx_push_data),
        .pop_n     (tx_pop_n),
        .count_o   (tx_count),
        .peek_o    (tx_peek),
        .ovf_o     (tx_ovf),
        .udf_o     (tx_udf)
    );

    sfe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_push_n),
        .push_data (rx_lane_data),
        .pop_n     (rx_pop_n),
        .count_o   (rx_count),
        .peek_o    (rx_peek),
        .ovf_o     (rx_ovf),
        .udf_o     (rx_udf)
    );

    sfe_event_ctrl #(.DEPTH(DEPTH)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_we  (reg_wr && addr == ADDR_MODE),
        .mask_we  (reg_wr && addr == ADDR_MASK),
        .evt_we   (reg_wr && addr == ADDR_EVT),
        .wdata    (reg_wdata),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_ovf   (rx_ovf),
        .rx_udf   (rx_udf),
        .tx_ovf   (tx_ovf),
        .tx_udf   (tx_udf),
        .rx_thr_o (rx_thr),
        .tx_thr_o (tx_thr),
        .flags_o  (flags),
        .mask_o   (mask),
        .irq_o    (irq)
    );

    // Read data assembly
    always_comb begin
        reg_rdata = '0;
        case (addr)
            ADDR_MODE: begin
                reg_rdata[RXTHR_LSB +: CW] = rx_thr;
                reg_rdata[TXTHR_LSB +: CW] = tx_thr;
            end
            ADDR_EVT: begin
                reg_rdata = flags_to_word(flags);
                reg_rdata[RXCNT_LSB +: CNT_FW] = CNT_FW'(rx_count);
                reg_rdata[TXCNT_LSB +: CNT_FW] = CNT_FW'(tx_count);
            end
            ADDR_MASK: reg_rdata = flags_to_word(mask);
            ADDR_RXD: begin
                if (reg_byte) begin
                    reg_rdata[7:0] = rx_peek[0];
                end else begin
                    for (int i = 0; i < LANES; i++) begin
                        reg_rdata[(LANES-1-i)*8 +: 8] = rx_peek[i];
                    end
                end
            end
            default: reg_rdata = '0;
        endcase
    end

    assign tx_head        = tx_peek[0];
    assign tx_has_data    = tx_count != '0;
    assign unused_tx_peek = ^tx_peek[LANES-1:1];

    a_one_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    p_irq_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

// File: tb/spi_fifo_event_unit_bench.sv
module spi_fifo_event_unit_bench;

    localparam logic [2:0] A_MODE = 3'd0, A_EVT = 3'd1, A_MASK = 3'd2,
                           A_TXD = 3'd3, A_RXD = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_byte = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_push_data = '0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_head;
    logic        tx_has_data;
    logic        irq;

    int          n_tests = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [7:0]  exp_rx[$];
    logic [7:0]  exp_tx[$];
    logic [31:0] rd_val;

    always #5 clk = ~clk;

    spi_fifo_event_unit u_spi_fifo_event_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_byte(reg_byte), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .tx_pop(tx_pop), .tx_head(tx_head), .tx_has_data(tx_has_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_read(input logic [2:0] a, input logic b, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a; reg_byte = b;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_byte = 1'b0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic b, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_byte = b; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_byte = 1'b0;
    endtask

    // Driver: shifter delivers a byte; the scoreboard queue gets it if it fits
    task automatic shift_in(input logic [7:0] v);
        rx_push = 1'b1; rx_push_data = v;
        if (exp_rx.size() < 32) exp_rx.push_back(v);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic tx_word(input logic [31:0] v);
        for (int i = 3; i >= 0; i--) exp_tx.push_back(v[i*8 +: 8]);
        reg_write(A_TXD, 1'b0, v);
    endtask

    // Monitor side: compare design output against the scoreboard head
    task automatic rx_word_check(input string req);
        logic [31:0] e;
        e = {exp_rx[0], exp_rx[1], exp_rx[2], exp_rx[3]};
        repeat (4) void'(exp_rx.pop_front());
        reg_read(A_RXD, 1'b0, rd_val);
        check(req, rd_val, e);
    endtask

    task automatic rx_byte_check(input string req);
        logic [7:0] e;
        e = exp_rx.pop_front();
        reg_read(A_RXD, 1'b1, rd_val);
        check(req, {24'd0, rd_val[7:0]}, {24'd0, e});
    endtask

    task automatic tx_drain_check(input string req);
        while (exp_tx.size() > 0) begin
            check(req, {24'd0, tx_head}, {24'd0, exp_tx.pop_front()});
            tx_pop = 1'b1;
            @(negedge clk);
            tx_pop = 1'b0;
        end
    endtask

    task automatic evt(output logic [31:0] d);
        reg_read(A_EVT, 1'b0, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        reg_read(A_MODE, 1'b0, rd_val); check("R1 mode", rd_val, 32'h0000_0403);
        reg_read(A_MASK, 1'b0, rd_val); check("R1 mask", rd_val, 32'h0);
        evt(rd_val);                    check("R1 event", rd_val, 32'h0000_0100);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R4 tx_has_data empty", {31'd0, tx_has_data}, 32'd0);

        // R2/R5: receive count and threshold 3
        shift_in(8'hA1); shift_in(8'hA2); shift_in(8'hA3);
        idle(1);
        evt(rd_val);
        check("R2 rx count 3", {26'd0, rd_val[29:24]}, 32'd3);
        check("R5 ne clear at 3", {31'd0, rd_val[9]}, 32'd0);
        shift_in(8'hA4);
        idle(1);
        evt(rd_val);
        check("R5 ne set at 4", rd_val, 32'h0400_0300);

        // R7 / R6: mask and clear while condition holds
        reg_write(A_MASK, 1'b0, 32'h0000_0200);
        check("R7 irq on ne", {31'd0, irq}, 32'd1);
        reg_write(A_EVT, 1'b0, 32'h0000_0200);
        evt(rd_val);
        check("R6 clear blocked by condition", {31'd0, rd_val[9]}, 32'd1);

        // R3: word read
        rx_word_check("R3 word read order");
        evt(rd_val);
        check("R2 rx count 0", {26'd0, rd_val[29:24]}, 32'd0);
        reg_write(A_EVT, 1'b0, 32'h0000_0200);
        idle(1);
        evt(rd_val);
        check("R6 ne cleared", {31'd0, rd_val[9]}, 32'd0);
        check("R7 irq low after clear", {31'd0, irq}, 32'd0);
        reg_write(A_MASK, 1'b0, 32'h0);

        // R3: byte read then word read
        for (int i = 0; i < 5; i++) shift_in(8'hB0 + 8'(i));
        rx_byte_check("R3 byte read");
        evt(rd_val);
        check("R3 byte pop count", {26'd0, rd_val[29:24]}, 32'd4);
        rx_word_check("R3 word after byte");

        // R9: byte read from empty receive FIFO
        reg_read(A_RXD, 1'b1, rd_val);
        evt(rd_val);
        check("R9 rx udf count", {26'd0, rd_val[29:24]}, 32'd0);
        check("R9 rx udf flag", {31'd0, rd_val[1]}, 32'd1);
        reg_write(A_MASK, 1'b0, 32'h0000_0002);
        check("R7 irq on udf", {31'd0, irq}, 32'd1);
        reg_write(A_EVT, 1'b0, 32'hFFFF_FFFF);
        evt(rd_val);
        check("R6 clear all", rd_val, 32'h0000_0100);
        check("R7 irq after clear all", {31'd0, irq}, 32'd0);

        // R4: transmit ordering
        tx_word(32'h1122_3344);
        exp_tx.push_back(8'h55);
        reg_write(A_TXD, 1'b1, 32'hFFFF_FF55);
        evt(rd_val);
        check("R2 tx count 5", {26'd0, rd_val[21:16]}, 32'd5);
        check("R4 tx_has_data", {31'd0, tx_has_data}, 32'd1);
        tx_drain_check("R4 tx head order");
        tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        evt(rd_val);
        check("R9 tx udf count", {26'd0, rd_val[21:16]}, 32'd0);
        check("R9 tx udf flag", {31'd0, rd_val[3]}, 32'd1);

        // R5/R6: thresholds tx=32, rx=0
        reg_write(A_MODE, 1'b0, 32'h0000_2000);
        reg_read(A_MODE, 1'b0, rd_val); check("R1 mode write", rd_val, 32'h0000_2000);
        exp_tx.push_back(8'h66);
        reg_write(A_TXD, 1'b1, 32'h66);
        idle(1);
        reg_write(A_EVT, 1'b0, 32'h0000_0100);
        idle(1);
        evt(rd_val);
        check("R6 nf cleared without condition", {31'd0, rd_val[8]}, 32'd0);
        tx_drain_check("R4 single byte");
        idle(1);
        evt(rd_val);
        check("R5 nf set at free 32", {31'd0, rd_val[8]}, 32'd1);
        reg_write(A_EVT, 1'b0, 32'h0000_0200);
        shift_in(8'hC1);
        idle(1);
        evt(rd_val);
        check("R5 ne with threshold 0", {31'd0, rd_val[9]}, 32'd1);
        rx_byte_check("R3 byte drain");

        // R10/R8: transmit capacity
        for (int i = 0; i < 8; i++) tx_word(32'hD000_0000 + 32'(i) * 32'h0101_0101);
        evt(rd_val);
        check("R10 tx full count", {26'd0, rd_val[21:16]}, 32'd32);
        reg_write(A_TXD, 1'b1, 32'hEE);
        evt(rd_val);
        check("R8 tx ovf count", {26'd0, rd_val[21:16]}, 32'd32);
        check("R8 tx ovf flag", {31'd0, rd_val[2]}, 32'd1);
        tx_drain_check("R10 tx full drain");

        // R10/R8: receive capacity
        for (int i = 0; i < 32; i++) shift_in(8'h80 + 8'(i));
        evt(rd_val);
        check("R10 rx full count", {26'd0, rd_val[29:24]}, 32'd32);
        shift_in(8'hFF);
        evt(rd_val);
        check("R8 rx ovf count", {26'd0, rd_val[29:24]}, 32'd32);
        check("R8 rx ovf flag", {31'd0, rd_val[0]}, 32'd1);
        reg_write(A_MASK, 1'b0, 32'h0000_0001);
        check("R7 irq on rx ovf", {31'd0, irq}, 32'd1);
        for (int i = 0; i < 8; i++) rx_word_check("R3 full drain");

        // R9: word read with only two bytes
        shift_in(8'hE1); shift_in(8'hE2);
        reg_read(A_RXD, 1'b0, rd_val);
        evt(rd_val);
        check("R9 partial word read count", {26'd0, rd_val[29:24]}, 32'd2);

        // R11: push and byte read in the same cycle
        rx_push = 1'b1; rx_push_data = 8'h5A;
        reg_rd = 1'b1; reg_addr = A_RXD; reg_byte = 1'b1;
        #1 check("R11 head during overlap", {24'd0, reg_rdata[7:0]}, {24'd0, exp_rx[0]});
        void'(exp_rx.pop_front());
        exp_rx.push_back(8'h5A);
        @(negedge clk);
        rx_push = 1'b0; reg_rd = 1'b0; reg_byte = 1'b0;
        evt(rd_val);
        check("R11 count unchanged", {26'd0, rd_val[29:24]}, 32'd2);

        // R6: clear all keeps counts, conditions re-set
        reg_write(A_EVT, 1'b0, 32'hFFFF_FFFF);
        evt(rd_val);
        check("R6 counts survive clear", rd_val, 32'h0200_0300);
        rx_byte_check("R11 order after overlap");
        rx_byte_check("R11 pushed byte");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule